// File: doc/BRIEF.md
# Event Timer Interrupt Router with Legacy Takeover

This block is the output stage of a multi-channel event timer. Each channel raises a one-cycle `fire` strobe when its comparator matches. The router turns that strobe into one of three things: a held level on an interrupt line, a one-clock pulse on an interrupt line, or a message-write request that carries an address and a data word. The channel's configuration word picks the outcome. The line is chosen by a route field inside that configuration word.

A legacy takeover mode makes the block drive the two interrupt lines that an external interval timer and a real-time clock normally own. While the mode is on, channel 0 is pinned to line 0 and channel 1 to line 8, and both external sources are blocked. While the mode is off, both external sources pass through to those lines. The real-time-clock level is captured on every cycle, so line 8 shows the correct level again as soon as the mode is left. An enable output tells the external interval timer whether it may run.

Top module: `evt_irq_router`

## Requirements
- R1: After reset, all interrupt lines, all status bits and `msg_req` are 0, and `ext_timer_en` is 1.
- R2: A channel is active when `glob_en` is 1 and both config bit 1 (enable) and bit 0 (level type) are set, with bit 2 (message) clear. On a `fire`, an active channel sets its `status` bit from the next cycle on. The bit stays set until a cycle with that channel's `clr` bit high and no `fire`.
- R3: A channel with config bit 1 set and bits 0 and 2 clear, under `glob_en`, produces a pulse exactly one clock wide on its line for each `fire`. The pulse appears in the cycle after the strobe.
- R4: A channel loses its status bit and stops driving its line in the cycle after `glob_en` is low or its enable bit is clear.
- R5: Outside legacy mode, each channel drives the line given by config bits [8:4] (mask 0x1F0, shift 4). Channels 2 and up always use this field.
- R6: In legacy mode, channel 0 drives line 0 and channel 1 drives line 8, whatever their route fields hold.
- R7: Outside legacy mode, `ext_timer_irq` appears on line 0 and `rtc_irq` on line 8, one cycle later. In legacy mode, both inputs have no effect on any line.
- R8: The `rtc_irq` level is captured every cycle, including in legacy mode. In the cycle after legacy mode is left, line 8 shows the current real-time-clock level.
- R9: `ext_timer_en` is 0 in the cycle after `legacy_mode` is 1, and 1 in the cycle after it is 0.
- R10: A `fire` on an enabled channel with config bit 2 set, under `glob_en`, drives no line. Instead it gives `msg_req` for one cycle, with `msg_addr` taken from bits [63:32] of that channel's message word and `msg_data` from bits [31:0]. When several such channels fire together, the lowest-numbered one wins.
- R11: Setting config bit 2 clears the channel's pending status bit and its line in the next cycle.
- R12: When several sources target one line, the line is their OR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glob_en | input | 1 | Global interrupt enable |
| legacy_mode | input | 1 | Legacy takeover mode request |
| chan_cfg | input | NCHAN*16 | Per-channel config words, channel 0 in the low bits |
| msg_word | input | NCHAN*64 | Per-channel message address (upper half) and data (lower half) |
| fire | input | NCHAN | Per-channel comparator-match strobe |
| clr | input | NCHAN | Per-channel status clear |
| ext_timer_irq | input | 1 | Interrupt from the external interval timer |
| rtc_irq | input | 1 | Interrupt level from the real-time clock |
| irq_lines | output | NLINES | Interrupt line outputs |
| status | output | NCHAN | Pending level status per channel |
| ext_timer_en | output | 1 | Run permission for the external interval timer |
| msg_req | output | 1 | Message write request strobe |
| msg_addr | output | 32 | Message write address |
| msg_data | output | 32 | Message write data |

## Verification
The assertions assume that `glob_en` and `legacy_mode` are synchronous levels that are stable around the clock edge. They also assume that a low global enable alone is enough to silence every channel-driven output in the next cycle. No assertion depends on the shape of the config words. The stimulus changes all inputs only at the falling edge. It holds config words for several cycles and weights route fields toward lines 0 and 8, so that legacy takeover and OR-combining occur often. It also keeps `legacy_mode` toggling rarely, so that both entry and exit are seen with the real-time-clock input at either level.

// File: rtl/ir_pkg.sv
package ir_pkg;
   localparam int CFG_W       = 16;
   localparam int BIT_LEVEL   = 0;
   localparam int BIT_EN      = 1;
   localparam int BIT_MSG     = 2;
   localparam int ROUTE_LSB   = 4;
   localparam int ROUTE_MAX_W = 5;
   localparam logic [CFG_W-1:0] ROUTE_MASK = 16'h01F0;
   localparam int LINE_TMR    = 0;
   localparam int LINE_RTC    = 8;
   localparam int MSG_W       = 64;

   function automatic logic [ROUTE_MAX_W-1:0] route_of(input logic [CFG_W-1:0] c);
      logic [CFG_W-1:0] t;
      t = (c & ROUTE_MASK) >> ROUTE_LSB;
      return t[ROUTE_MAX_W-1:0];
   endfunction
endpackage

// File: rtl/ir_chan_stage.sv
module ir_chan_stage
   import ir_pkg::*;
#(
   parameter int NCHAN = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   glob_en,
   input  logic [NCHAN*CFG_W-1:0] cfg,
   input  logic [NCHAN-1:0]       fire,
   input  logic [NCHAN-1:0]       clr,
   output logic [NCHAN-1:0]       status,
   output logic [NCHAN-1:0]       pulse
);
   for (genvar i = 0; i < NCHAN; i++) begin : g_ch
      logic [CFG_W-1:0] c;
      logic             act;
      logic             st_q, pu_q;
      assign c   = cfg[i*CFG_W +: CFG_W];
      assign act = glob_en & c[BIT_EN] & ~c[BIT_MSG];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q <= 1'b0;
            pu_q <= 1'b0;
         end else begin
            st_q <= act & c[BIT_LEVEL] & (fire[i] | (st_q & ~clr[i]));
            pu_q <= act & ~c[BIT_LEVEL] & fire[i];
         end
      end
      assign status[i] = st_q;
      assign pulse[i]  = pu_q;
   end
endmodule

// File: rtl/ir_line_mux.sv
module ir_line_mux
   import ir_pkg::*;
#(
   parameter int NCHAN  = 3,
   parameter int NLINES = 32
) (
   input  logic                   legacy_q,
   input  logic [NCHAN*CFG_W-1:0] cfg,
   input  logic [NCHAN-1:0]       drive,
   input  logic                   ext_q,
   input  logic                   rtc_q,
   output logic [NLINES-1:0]      lines
);
   localparam int RW = $clog2(NLINES);

   function automatic logic [RW-1:0] pick(input int idx, input logic [CFG_W-1:0] c,
                                          input logic leg);
      logic [ROUTE_MAX_W-1:0] r;
      r = route_of(c);
      if (leg && idx == 0) return RW'(LINE_TMR);
      if (leg && idx == 1) return RW'(LINE_RTC);
      return r[RW-1:0];
   endfunction

   always_comb begin
      lines = '0;
      for (int i = 0; i < NCHAN; i++) begin
         if (drive[i]) lines[pick(i, cfg[i*CFG_W +: CFG_W], legacy_q)] = 1'b1;
      end
      if (!legacy_q) begin
         lines[LINE_TMR] = lines[LINE_TMR] | ext_q;
         lines[LINE_RTC] = lines[LINE_RTC] | rtc_q;
      end
   end
endmodule

// File: rtl/ir_msg_arb.sv
module ir_msg_arb
   import ir_pkg::*;
#(
   parameter int NCHAN = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   glob_en,
   input  logic [NCHAN*CFG_W-1:0] cfg,
   input  logic [NCHAN*MSG_W-1:0] word,
   input  logic [NCHAN-1:0]       fire,
   output logic                   req,
   output logic [31:0]            addr,
   output logic [31:0]            data
);
   logic        hit;
   logic [31:0] sel_a, sel_d;

   always_comb begin
      hit   = 1'b0;
      sel_a = '0;
      sel_d = '0;
      for (int i = NCHAN - 1; i >= 0; i--) begin
         if (fire[i] && glob_en && cfg[i*CFG_W + BIT_EN] && cfg[i*CFG_W + BIT_MSG]) begin
            hit   = 1'b1;
            sel_a = word[i*MSG_W + 32 +: 32];
            sel_d = word[i*MSG_W +: 32];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req  <= 1'b0;
         addr <= '0;
         data <= '0;
      end else begin
         req <= hit;
         if (hit) begin
            addr <= sel_a;
            data <= sel_d;
         end
      end
   end
endmodule

// File: rtl/evt_irq_router.sv
module evt_irq_router
   import ir_pkg::*;
#(
   parameter int NCHAN  = 3,
   parameter int NLINES = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         glob_en,
   input  logic                         legacy_mode,
   input  logic [NCHAN*ir_pkg::CFG_W-1:0] chan_cfg,
   input  logic [NCHAN*ir_pkg::MSG_W-1:0] msg_word,
   input  logic [NCHAN-1:0]             fire,
   input  logic [NCHAN-1:0]             clr,
   input  logic                         ext_timer_irq,
   input  logic                         rtc_irq,
   output logic [NLINES-1:0]            irq_lines,
   output logic [NCHAN-1:0]             status,
   output logic                         ext_timer_en,
   output logic                         msg_req,
   output logic [31:0]                  msg_addr,
   output logic [31:0]                  msg_data
);
   initial begin
      assert (NCHAN >= 2 && NCHAN <= 32) else $error("NCHAN out of range");
      assert (NLINES > LINE_RTC && NLINES <= (1 << ROUTE_MAX_W)) else $error("NLINES out of range");
      assert ((NLINES & (NLINES - 1)) == 0) else $error("NLINES must be a power of two");
   end

   logic             legacy_q, ext_q, rtc_q, run_q;
   logic [NCHAN-1:0] pulse;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         legacy_q <= 1'b0;
         ext_q    <= 1'b0;
         rtc_q    <= 1'b0;
         run_q    <= 1'b1;
      end else begin
         legacy_q <= legacy_mode;
         ext_q    <= ext_timer_irq;
         rtc_q    <= rtc_irq;
         run_q    <= ~legacy_mode;
      end
   end
   assign ext_timer_en = run_q;

   ir_chan_stage #(.NCHAN(NCHAN)) u_chan (
      .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .cfg(chan_cfg),
      .fire(fire), .clr(clr), .status(status), .pulse(pulse));

   ir_line_mux #(.NCHAN(NCHAN), .NLINES(NLINES)) u_mux (
      .legacy_q(legacy_q), .cfg(chan_cfg), .drive(status | pulse),
      .ext_q(ext_q), .rtc_q(rtc_q), .lines(irq_lines));

   ir_msg_arb #(.NCHAN(NCHAN)) u_msg (
      .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .cfg(chan_cfg),
      .word(msg_word), .fire(fire), .req(msg_req), .addr(msg_addr), .data(msg_data));
endmodule

module evt_irq_router_chk #(
   parameter int NCHAN  = 3,
   parameter int NLINES = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              glob_en,
   input logic              legacy_mode,
   input logic              ext_timer_en,
   input logic              msg_req,
   input logic [NCHAN-1:0]  status,
   input logic [NLINES-1:0] irq_lines
);
   assert_run_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      legacy_mode |=> !ext_timer_en);
   assert_run_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !legacy_mode |=> ext_timer_en);
   assert_gate_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !glob_en |=> (status == '0));
   assert_gate_msg_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !glob_en |=> !msg_req);
   assert_block_ext_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (legacy_mode && !glob_en) |=> (!irq_lines[0] && !irq_lines[8]));
endmodule

bind evt_irq_router evt_irq_router_chk #(.NCHAN(NCHAN), .NLINES(NLINES)) u_chk (
   .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .legacy_mode(legacy_mode),
   .ext_timer_en(ext_timer_en), .msg_req(msg_req), .status(status), .irq_lines(irq_lines));

// File: tb/evt_irq_router_tb.sv
module evt_irq_router_tb_top;
   localparam int NC = 3;
   localparam int NL = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic              glob_en = 0, legacy_mode = 0, ext_in = 0, rtc_in = 0;
   logic [NC*16-1:0]  cfg = '0;
   logic [NC*64-1:0]  mw = '0;
   logic [NC-1:0]     fire = '0, clr = '0;
   logic [NL-1:0]     irq_lines;
   logic [NC-1:0]     status;
   logic              ext_timer_en, msg_req;
   logic [31:0]       msg_addr, msg_data;

   evt_irq_router #(.NCHAN(NC), .NLINES(NL)) dut_i (
      .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .legacy_mode(legacy_mode),
      .chan_cfg(cfg), .msg_word(mw), .fire(fire), .clr(clr),
      .ext_timer_irq(ext_in), .rtc_irq(rtc_in), .irq_lines(irq_lines),
      .status(status), .ext_timer_en(ext_timer_en), .msg_req(msg_req),
      .msg_addr(msg_addr), .msg_data(msg_data));

   int n_chk = 0, n_bad = 0;
   logic [NC-1:0] m_st = '0, m_pu = '0;
   logic m_leg = 0, m_ext = 0, m_rtc = 0, m_req = 0;
   logic [31:0] m_a = 0, m_d = 0;

   task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [4:0] route(input int i);
      logic [15:0] c;
      c = cfg[i*16 +: 16];
      if (m_leg && i == 0) return 5'd0;
      if (m_leg && i == 1) return 5'd8;
      return c[8:4];
   endfunction

   function automatic logic [NL-1:0] exp_lines();
      logic [NL-1:0] l;
      l = '0;
      for (int i = 0; i < NC; i++) if (m_st[i] | m_pu[i]) l[route(i)] = 1'b1;
      if (!m_leg) begin
         l[0] = l[0] | m_ext;
         l[8] = l[8] | m_rtc;
      end
      return l;
   endfunction

   // advance the model over one clock edge using the currently driven inputs
   task automatic step_and_check();
      logic [NC-1:0] ns, np;
      logic hit;
      hit = 0;
      for (int i = 0; i < NC; i++) begin
         logic [15:0] c;
         logic act;
         c = cfg[i*16 +: 16];
         act = glob_en & c[1] & ~c[2];
         ns[i] = act & c[0] & (fire[i] | (m_st[i] & ~clr[i]));
         np[i] = act & ~c[0] & fire[i];
      end
      for (int i = NC - 1; i >= 0; i--)
         if (fire[i] && glob_en && cfg[i*16+1] && cfg[i*16+2]) begin
            hit = 1; m_a = mw[i*64+32 +: 32]; m_d = mw[i*64 +: 32];
         end
      m_req = hit; m_st = ns; m_pu = np;
      m_leg = legacy_mode; m_ext = ext_in; m_rtc = rtc_in;
      @(posedge clk);
      @(negedge clk);
      chk(64'(status), 64'(m_st), "R2 status");
      chk(64'(irq_lines), 64'(exp_lines()), "R5 R12 lines");
      chk(64'(ext_timer_en), 64'(!m_leg), "R9 ext_timer_en");
      chk(64'(msg_req), 64'(m_req), "R10 msg_req");
      if (m_req) chk({msg_addr, msg_data}, {m_a, m_d}, "R10 msg fields");
   endtask

   function automatic logic [15:0] mkcfg(input logic lvl, input logic en, input logic msg,
                                         input logic [4:0] rt);
      return {7'd0, rt, 1'b0, msg, en, lvl};
   endfunction

   initial begin : watchdog
      #1000000;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      chk(64'(irq_lines), 0, "R1 lines");
      chk(64'(status), 0, "R1 status");
      chk(64'(msg_req), 0, "R1 msg_req");
      chk(64'(ext_timer_en), 1, "R1 ext_timer_en");
      rst_n = 1;
      @(negedge clk);

      // R3 edge pulse on line 5 from channel 2
      glob_en = 1;
      cfg[32 +: 16] = mkcfg(0, 1, 0, 5'd5);
      fire = 3'b100; step_and_check();
      chk(64'(irq_lines[5]), 1, "R3 pulse high");
      fire = 0; step_and_check();
      chk(64'(irq_lines[5]), 0, "R3 pulse one clock");

      // R2 level hold, R11 message enable clears it
      cfg[32 +: 16] = mkcfg(1, 1, 0, 5'd5);
      fire = 3'b100; step_and_check();
      fire = 0; repeat (3) step_and_check();
      chk(64'(status[2]), 1, "R2 held");
      cfg[32 +: 16] = mkcfg(1, 1, 1, 5'd5); step_and_check();
      chk(64'(status[2]), 0, "R11 cleared");
      chk(64'(irq_lines[5]), 0, "R11 line low");

      // R4 disable clears level
      cfg[32 +: 16] = mkcfg(1, 1, 0, 5'd5);
      fire = 3'b100; step_and_check(); fire = 0;
      glob_en = 0; step_and_check();
      chk(64'(status[2]), 0, "R4 global off");
      glob_en = 1;

      // R10 priority: channels 1 and 2 both message
      cfg[16 +: 16] = mkcfg(0, 1, 1, 5'd3);
      cfg[32 +: 16] = mkcfg(0, 1, 1, 5'd3);
      mw[64 +: 64]  = 64'hAAAA_0001_1111_0001;
      mw[128 +: 64] = 64'hBBBB_0002_2222_0002;
      fire = 3'b110; step_and_check(); fire = 0;
      chk({32'(msg_req), msg_data}, {32'd1, 32'h1111_0001}, "R10 lowest wins");
      chk(64'(irq_lines[3]), 0, "R10 no line");

      // R7, R8, R6 legacy entry and exit with RTC high
      cfg = '0;
      ext_in = 1; rtc_in = 1; step_and_check();
      chk(64'({irq_lines[8], irq_lines[0]}), 2'b11, "R7 pass through");
      legacy_mode = 1; step_and_check();
      chk(64'({irq_lines[8], irq_lines[0]}), 0, "R7 blocked");
      rtc_in = 0; step_and_check(); rtc_in = 1; step_and_check();
      cfg[0 +: 16]  = mkcfg(1, 1, 0, 5'd20);
      fire = 3'b001; step_and_check(); fire = 0;
      chk(64'({irq_lines[20], irq_lines[0]}), 2'b01, "R6 forced line 0");
      cfg[0 +: 16] = 0; step_and_check();
      legacy_mode = 0; step_and_check();
      chk(64'(irq_lines[8]), 1, "R8 rtc restored");

      // constrained random
      for (int k = 0; k < 3000; k++) begin
         glob_en = ($urandom_range(99) < 88);
         if ($urandom_range(99) < 6) legacy_mode = ~legacy_mode;
         if ($urandom_range(99) < 15) ext_in = ~ext_in;
         if ($urandom_range(99) < 15) rtc_in = ~rtc_in;
         for (int i = 0; i < NC; i++) begin
            if ($urandom_range(99) < 6) begin
               logic [4:0] rt;
               rt = ($urandom_range(1)) ? (($urandom_range(1)) ? 5'd0 : 5'd8) : 5'($urandom);
               cfg[i*16 +: 16] = mkcfg(1'($urandom), ($urandom_range(9) < 8),
                                       ($urandom_range(9) < 2), rt);
               mw[i*64 +: 64] = {$urandom, $urandom};
            end
            fire[i] = ($urandom_range(99) < 30);
            clr[i]  = ($urandom_range(99) < 15);
         end
         step_and_check();
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule